// File: doc/BRIEF.md
# Maintenance Interrupt Status Aggregator

This block collects maintenance error reasons for a core that runs several hardware threads and drives one maintenance interrupt line per thread. Every thread owns a private copy of an exception status register. Error reasons arrive on a single event vector, and each event is written into all thread copies in the same cycle. A thread acknowledges a reason by clearing bits in its own copy only. The copies of the other threads are not touched.

One enable mask is shared by the whole core. It decides which status bits may raise an interrupt. Software loads the mask through a plain write port. A thread's interrupt line is the registered OR of its status bits that are also enabled. Each status copy can be read back at the ports so that a handler can find out why it was interrupted.

Some bit positions have fixed meanings:
- Bit 0: malfunction alert, covering a checkstop of the core or of an attached accelerator.
- Bits 2, 3 and 11: recovered processor retry events.
- Bit 4: a timer facility error.

Top module: `maint_irq_agg`

## Requirements
- R1: After reset, every status bit, every enable bit and every interrupt output is 0.
- R2: An event bit set in `evt_i` sets that bit in the status copy of every thread on the next clock edge.
- R3: Status bits are sticky. A bit stays set until its own thread clears it.
- R4: Asserting `clr_vld_i[t]` with `clr_mask_i` clears, in thread t only, each status bit whose mask bit is 1. The status of every other thread is unchanged.
- R5: If an event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R6: When `en_we_i` is 1, `en_wdata_i` replaces the shared enable mask on the next edge. When `en_we_i` is 0, the mask holds its value.
- R7: `irq_o[t]` is 1 exactly when thread t has at least one status bit that is also enabled. The output is registered, so it follows a change of status or enable one cycle later.
- R8: A status bit whose enable bit is 0 does not raise the interrupt. It is still reported on `status_o`.
- R9: The fixed error classes sit at these positions: malfunction alert on bit 0, retry recovery on bits 2, 3 and 11, and timer facility error on bit 4. Each class raises the interrupt when its own bit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | W | Error reason pulses, sent to all threads |
| clr_vld_i | input | T | Per-thread clear strobe |
| clr_mask_i | input | T*W | Per-thread write-one-to-clear mask; thread t uses slice [t*W +: W] |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | W | Enable register write data |
| en_o | output | W | Current enable mask |
| status_o | output | T*W | Status copies; thread t at [t*W +: W] |
| irq_o | output | T | Per-thread maintenance interrupt |

## Verification
Each state element is visible at the ports within one cycle.

A wrong status bit appears on `status_o` one edge after the stimulus. It reaches `irq_o` one edge after that, and only if the bit is enabled.

A wrong enable bit appears on `en_o` at once. It also changes the interrupt of every thread that holds the matching status bit.

A clear that leaks into a neighbouring thread, or an event that loses to a clear, shows directly in the readback of the affected copy.

// File: rtl/maint_irq_pkg.sv
package maint_irq_pkg;
    localparam int unsigned BIT_MALFUNC   = 0;
    localparam int unsigned BIT_RETRY_A   = 2;
    localparam int unsigned BIT_RETRY_B   = 3;
    localparam int unsigned BIT_TIMER     = 4;
    localparam int unsigned BIT_RETRY_C   = 11;
    localparam int unsigned MIN_STAT_W    = 12;
endpackage

// File: rtl/maint_stat_copy.sv
module maint_stat_copy #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic         clr_vld_i,
    input  logic [W-1:0] clr_mask_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic         irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_vld_i) st_d.stat = st_q.stat & ~clr_mask_i;
        st_d.stat = st_d.stat | evt_i;
        st_d.irq  = |(st_q.stat & en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.stat;
    assign irq_o    = st_q.irq;

    // R5: event beats clear
    a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));
    // R3: without clear nothing falls
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_vld_i |=> ((status_o & $past(status_o)) == $past(status_o)));
    // R7: irq follows enabled status one cycle later
    a_r7_irq_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == |($past(status_o) & $past(en_i))));
endmodule

// File: rtl/maint_en_reg.sv
module maint_en_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (we_i) en_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= en_d;
    end

    assign en_o = en_q;

    // R6: mask holds without a write
    a_r6_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(en_o));
endmodule

// File: rtl/maint_irq_agg.sv
module maint_irq_agg #(
    parameter int unsigned T = 4,
    parameter int unsigned W = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [W-1:0]   evt_i,
    input  logic [T-1:0]   clr_vld_i,
    input  logic [T*W-1:0] clr_mask_i,
    input  logic           en_we_i,
    input  logic [W-1:0]   en_wdata_i,
    output logic [W-1:0]   en_o,
    output logic [T*W-1:0] status_o,
    output logic [T-1:0]   irq_o
);
    import maint_irq_pkg::*;

    initial begin
        if (W < MIN_STAT_W) $error("status width too small for fixed bits");
    end

    logic [W-1:0] en_w;

    maint_en_reg #(.W(W)) u_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_w)
    );

    assign en_o = en_w;

    for (genvar t = 0; t < T; t++) begin : g_thr
        maint_stat_copy #(.W(W)) u_copy (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .evt_i      (evt_i),
            .clr_vld_i  (clr_vld_i[t]),
            .clr_mask_i (clr_mask_i[t*W +: W]),
            .en_i       (en_w),
            .status_o   (status_o[t*W +: W]),
            .irq_o      (irq_o[t])
        );

        // R4: a thread without clear keeps bits other threads clear
        a_r4_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !clr_vld_i[t] |=> ((status_o[t*W +: W] & $past(status_o[t*W +: W]))
                               == $past(status_o[t*W +: W])));
    end

    // R2: broadcast, all copies see the event
    for (genvar t = 1; t < T; t++) begin : g_bc
        a_r2_broadcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> ((status_o[t*W +: W] & $past(evt_i)) ==
                      (status_o[0 +: W] & $past(evt_i))));
    end
endmodule

// File: tb/tb_maint_irq_agg.sv
module tb_maint_irq_agg;
    localparam int T = 4;
    localparam int W = 16;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [W-1:0]   evt = '0;
    logic [T-1:0]   clr_vld = '0;
    logic [T*W-1:0] clr_mask = '0;
    logic           en_we = 0;
    logic [W-1:0]   en_wdata = '0;
    logic [W-1:0]   en;
    logic [T*W-1:0] status;
    logic [T-1:0]   irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    maint_irq_agg #(.T(T), .W(W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .clr_vld_i(clr_vld),
        .clr_mask_i(clr_mask), .en_we_i(en_we), .en_wdata_i(en_wdata),
        .en_o(en), .status_o(status), .irq_o(irq));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on negedge, one posedge, sample at next negedge
    task automatic step();
        @(posedge clk); @(negedge clk);
        evt = '0; clr_vld = '0; clr_mask = '0; en_we = 0;
    endtask

    function automatic logic [W-1:0] st(int t);
        return status[t*W +: W];
    endfunction

    task automatic do_reset();
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic t_reset();
        chk("R1 status", status, '0);
        chk("R1 enable", en, '0);
        chk("R1 irq", irq, '0);
    endtask

    task automatic t_broadcast();
        evt = 16'h0010; step();
        for (int t = 0; t < T; t++) chk("R2 broadcast", st(t), 16'h0010);
        chk("R8 disabled no irq", irq, '0);
        step(); step();
        chk("R3 sticky", status, {T{16'h0010}});
        chk("R8 still no irq", irq, '0);
    endtask

    task automatic t_enable();
        en_we = 1; en_wdata = 16'h0010; step();
        chk("R6 en write", en, 16'h0010);
        chk("R7 irq not yet", irq, '0);
        step();
        chk("R7 irq one cycle later", irq, {T{1'b1}});
        en_wdata = 16'hFFFF; step();
        chk("R6 en hold", en, 16'h0010);
    endtask

    task automatic t_clear();
        clr_vld = 4'b0100; clr_mask[2*W +: W] = 16'h0010;
        clr_mask[1*W +: W] = 16'h0010;   // ignored, clr_vld[1]=0
        step();
        chk("R4 cleared thread 2", st(2), '0);
        chk("R4 thread 1 intact", st(1), 16'h0010);
        chk("R4 thread 0 intact", st(0), 16'h0010);
        chk("R7 irq before update", irq, 4'b1111);
        step();
        chk("R7 irq thread 2 drops", irq, 4'b1011);
    endtask

    task automatic t_race();
        evt = 16'h0001; clr_vld = 4'b0001; clr_mask[0 +: W] = 16'h0011;
        step();
        chk("R5 event wins", st(0), 16'h0001);
        chk("R5 others", st(3), 16'h0011);
    endtask

    task automatic t_classes();
        do_reset();
        evt = 16'h081D; step();
        chk("R9 all classes set", st(1), 16'h081D);
        for (int b = 0; b < W; b++) begin
            en_we = 1; en_wdata = 16'h1 << b; step(); step();
            chk($sformatf("R9 bit %0d", b), irq,
                ((16'h081D >> b) & 1) ? {T{1'b1}} : '0);
        end
        en_we = 1; en_wdata = 16'h0800; step();
        clr_vld = 4'b1111; clr_mask = {T{16'h0800}}; step(); step();
        chk("R9 retry bit 11 cleared irq", irq, '0);
        chk("R8 other bits reported", st(3), 16'h001D);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R1 status in reset", status, '0);
        rst_n = 1; @(negedge clk);
        t_reset();
        t_broadcast();
        t_enable();
        t_clear();
        t_race();
        t_classes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule